// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets software read, program and erase a word-organised embedded flash through a small set of memory-mapped registers. Software first loads a target byte address, a data word and a command code. It then sets a start bit in the trigger register. The controller checks the request in one cycle against the address map and the region permissions. If the request is allowed, it drives a request/done handshake towards the flash macro. When the operation finishes, it clears the start bit by itself.

A refused request never reaches the flash. Instead it sets a sticky fail flag in the control register. Every bit of the control, trigger and access-time registers is guarded by a write-protection gate. The gate opens after the bytes 0x59, 0x16 and 0x88 are written, in that order, to the unlock register. A read of the flash places the returned word in the data register.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, every register reads 0, except the boot-select bit, which reads the BOOT_RST parameter (default 0). The gate is locked and fl_req is low.
- R2: A read of the register at offset reg_addr appears on reg_rdata one clock later.
  - Offsets: 0x00 control, 0x04 address, 0x08 data, 0x0C command, 0x10 trigger, 0x14 data-region base (constant DATA_BASE), 0x18 access-time, 0x1C unlock status in bit 0.
  - Control bits: 0 enable, 1 boot select (1 means running from the loader region), 3 application-update enable, 4 config-update enable, 5 loader-update enable, 6 fail flag.
  - Any other offset reads 0.
- R3: The gate opens after 0x59, 0x16 and 0x88 are written in that order to offset 0x1C. A write that breaks the order returns the matcher to its start. Any write to 0x1C while the gate is open closes it again.
- R4: While the gate is locked, writes to the control, trigger and access-time registers have no effect.
- R5: The address, data and command registers can be written without unlocking. The command register holds the code in bits 3:0 and two stored bits at 5:4. Writes to these three registers are ignored while the trigger bit reads 1.
- R6: Writing 1 to trigger bit 0 with the gate open and the enable bit at 1 sets the trigger bit. With the enable bit at 0, the write is ignored and the trigger bit stays 0.
- R7: Command codes are 0x0 read, 0x1 program and 0x2 page erase. Any other code sets the fail flag and raises no flash request.
- R8: After the check cycle of an accepted operation, fl_req rises and stays high until fl_done. On fl_done the trigger bit clears. For a read, the data register takes fl_rdata.
- R9: A program or erase is refused when any of these holds:
  - the target is in the application region while boot select is 0 and application-update enable is 0;
  - the target is in the loader region while boot select is 1;
  - the target is in the loader region while boot select is 0 and loader-update enable is 0;
  - the target is in the config region while config-update enable is 0.
- R10: Any command is refused when address bits 1:0 are not 00, or when the address lies outside the application region [0, APP_BYTES), the loader region [LDR_BASE, LDR_BASE+LDR_BYTES) and the config region [CFG_BASE, CFG_BASE+CFG_BYTES).
- R11: The fail flag stays set until a control write with the gate open carries 1 in bit 6. Writing 0 in bit 6 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | OFS_W | Register byte offset for reads and writes |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Registered read data for the offset of the previous cycle |
| fl_req | output | 1 | Flash operation request, held until done |
| fl_cmd | output | 2 | Flash operation: 0 read, 1 program, 2 erase |
| fl_addr | output | W | Flash byte address |
| fl_wdata | output | W | Flash program data |
| fl_done | input | 1 | Flash completion pulse |
| fl_rdata | input | W | Flash read data, valid with fl_done |

## Verification
Several rules are checked by assertions on every cycle:
- the request stays high until done and never appears without the trigger bit;
- done clears the trigger bit;
- a refused check raises no request;
- the fail flag is sticky;
- the control register is stable while locked;
- the address is stable while busy;
- the trigger bit never rises with the enable bit off;
- an open gate closes on any unlock write.

Only the bench scenarios can show the rest. These are the exact region boundaries and the combinations of permission bits, the matcher's reset on a wrong byte, the read data landing in the data register, and writes made during a busy operation being dropped. A behavioural model compares the read data and the flash request on every clock.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_ADDR = 'h04;
  localparam int OFS_DATA = 'h08;
  localparam int OFS_CMD  = 'h0C;
  localparam int OFS_TRG  = 'h10;
  localparam int OFS_DBAS = 'h14;
  localparam int OFS_TIM  = 'h18;
  localparam int OFS_KEY  = 'h1C;

  localparam logic [3:0] OP_READ  = 4'h0;
  localparam logic [3:0] OP_PROG  = 4'h1;
  localparam logic [3:0] OP_ERASE = 4'h2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_CHECK, SQ_WAIT} sq_state_t;

  function automatic logic [7:0] key_at(input int idx);
    case (idx)
      0:       key_at = 8'h59;
      1:       key_at = 8'h16;
      2:       key_at = 8'h88;
      default: key_at = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/isp_unlock.sv
module isp_unlock import flash_isp_pkg::*; #(
  parameter int KEY_N = 3,
  localparam int CW = $clog2(KEY_N + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  logic [CW-1:0] pos;

  assign unlocked = (pos == CW'(KEY_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (key_wr) begin
      if (unlocked)                          pos <= '0;
      else if (key_byte == key_at(int'(pos))) pos <= pos + 1'b1;
      else                                    pos <= '0;
    end
  end

  // R3: a write while open always closes the gate
  assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && key_wr) |=> !unlocked);
endmodule

// File: rtl/isp_access_check.sv
module isp_access_check import flash_isp_pkg::*; #(
  parameter int W = 32,
  parameter logic [W-1:0] APP_BYTES = 32'h0000_8000,
  parameter logic [W-1:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [W-1:0] LDR_BYTES = 32'h0000_1000,
  parameter logic [W-1:0] CFG_BASE  = 32'h0030_0000,
  parameter logic [W-1:0] CFG_BYTES = 32'h0000_0008
) (
  input  logic [W-1:0] addr,
  input  logic [3:0]   code,
  input  logic         boot_ldr,
  input  logic         app_upd,
  input  logic         ldr_upd,
  input  logic         cfg_upd,
  output logic         bad
);
  localparam logic [W-1:0] LDR_END = LDR_BASE + LDR_BYTES;
  localparam logic [W-1:0] CFG_END = CFG_BASE + CFG_BYTES;

  logic in_app, in_ldr, in_cfg, known, modify, aligned, deny;

  always_comb begin
    in_app  = (addr < APP_BYTES);
    in_ldr  = (addr >= LDR_BASE) && (addr < LDR_END);
    in_cfg  = (addr >= CFG_BASE) && (addr < CFG_END);
    aligned = (addr[1:0] == 2'b00);
    known   = (code == OP_READ) || (code == OP_PROG) || (code == OP_ERASE);
    modify  = (code == OP_PROG) || (code == OP_ERASE);
    deny    = (in_app && !boot_ldr && !app_upd) ||
              (in_ldr && (boot_ldr || !ldr_upd)) ||
              (in_cfg && !cfg_upd);
    bad     = !known || !aligned || !(in_app || in_ldr || in_cfg) ||
              (modify && deny);
  end
endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer import flash_isp_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bad,
  input  logic op_read,
  input  logic fl_done,
  output logic go,
  output logic fl_req,
  output logic fail_set,
  output logic rd_load
);
  sq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      go     <= 1'b0;
      fl_req <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          go <= 1'b1;
          st <= SQ_CHECK;
        end
        SQ_CHECK: if (bad) begin
          go <= 1'b0;
          st <= SQ_IDLE;
        end else begin
          fl_req <= 1'b1;
          st     <= SQ_WAIT;
        end
        SQ_WAIT: if (fl_done) begin
          fl_req <= 1'b0;
          go     <= 1'b0;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign fail_set = (st == SQ_CHECK) && bad;
  assign rd_load  = (st == SQ_WAIT) && fl_done && op_read;

  assert_req_implies_go_R8: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> go);
  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_done) |=> fl_req);
  assert_done_clears_go_R8: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_done) |=> (!go && !fl_req));
  assert_refused_no_req_R9: assert property (@(posedge clk) disable iff (rst)
    fail_set |=> (!fl_req && !go));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl import flash_isp_pkg::*; #(
  parameter int W     = 32,
  parameter int OFS_W = 5,
  parameter int KEY_N = 3,
  parameter int TIM_W = 5,
  parameter int CMD_W = 6,
  parameter logic [W-1:0] APP_BYTES = 32'h0000_8000,
  parameter logic [W-1:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [W-1:0] LDR_BYTES = 32'h0000_1000,
  parameter logic [W-1:0] CFG_BASE  = 32'h0030_0000,
  parameter logic [W-1:0] CFG_BYTES = 32'h0000_0008,
  parameter logic [W-1:0] DATA_BASE = 32'h0000_7000,
  parameter logic         BOOT_RST  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             fl_req,
  output logic [1:0]       fl_cmd,
  output logic [W-1:0]     fl_addr,
  output logic [W-1:0]     fl_wdata,
  input  logic             fl_done,
  input  logic [W-1:0]     fl_rdata
);
  logic ctl_en, ctl_boot, ctl_app, ctl_cfg, ctl_ldr, ctl_fail;
  logic [W-1:0]     addr_q, data_q, rd_next;
  logic [CMD_W-1:0] cmd_q;
  logic [TIM_W-1:0] tim_q;
  logic unlocked, go, fail_set, rd_load, bad, start;
  logic wr_ctl, wr_addr, wr_data, wr_cmd, wr_trg, wr_tim, wr_key;

  assign wr_ctl  = reg_wr && (reg_addr == OFS_W'(OFS_CTL));
  assign wr_addr = reg_wr && (reg_addr == OFS_W'(OFS_ADDR));
  assign wr_data = reg_wr && (reg_addr == OFS_W'(OFS_DATA));
  assign wr_cmd  = reg_wr && (reg_addr == OFS_W'(OFS_CMD));
  assign wr_trg  = reg_wr && (reg_addr == OFS_W'(OFS_TRG));
  assign wr_tim  = reg_wr && (reg_addr == OFS_W'(OFS_TIM));
  assign wr_key  = reg_wr && (reg_addr == OFS_W'(OFS_KEY));

  isp_unlock #(.KEY_N(KEY_N)) u_unlock (
    .clk(clk), .rst(rst), .key_wr(wr_key), .key_byte(reg_wdata[7:0]),
    .unlocked(unlocked));

  isp_access_check #(.W(W), .APP_BYTES(APP_BYTES), .LDR_BASE(LDR_BASE),
    .LDR_BYTES(LDR_BYTES), .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES)) u_check (
    .addr(addr_q), .code(cmd_q[3:0]), .boot_ldr(ctl_boot), .app_upd(ctl_app),
    .ldr_upd(ctl_ldr), .cfg_upd(ctl_cfg), .bad(bad));

  assign start = wr_trg && unlocked && reg_wdata[0] && ctl_en && !go;

  isp_sequencer u_seq (
    .clk(clk), .rst(rst), .start(start), .bad(bad),
    .op_read(cmd_q[3:0] == OP_READ), .fl_done(fl_done), .go(go),
    .fl_req(fl_req), .fail_set(fail_set), .rd_load(rd_load));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= 1'b0; ctl_boot <= BOOT_RST; ctl_app <= 1'b0;
      ctl_cfg <= 1'b0; ctl_ldr <= 1'b0; ctl_fail <= 1'b0;
      addr_q <= '0; data_q <= '0; cmd_q <= '0; tim_q <= '0;
    end else begin
      if (wr_ctl && unlocked) begin
        ctl_en   <= reg_wdata[0];
        ctl_boot <= reg_wdata[1];
        ctl_app  <= reg_wdata[3];
        ctl_cfg  <= reg_wdata[4];
        ctl_ldr  <= reg_wdata[5];
      end
      if (fail_set)                               ctl_fail <= 1'b1;
      else if (wr_ctl && unlocked && reg_wdata[6]) ctl_fail <= 1'b0;
      if (wr_addr && !go) addr_q <= reg_wdata;
      if (rd_load)                data_q <= fl_rdata;
      else if (wr_data && !go)    data_q <= reg_wdata;
      if (wr_cmd && !go)  cmd_q <= reg_wdata[CMD_W-1:0];
      if (wr_tim && unlocked) tim_q <= reg_wdata[TIM_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      OFS_W'(OFS_CTL): begin
        rd_next[0] = ctl_en;  rd_next[1] = ctl_boot; rd_next[3] = ctl_app;
        rd_next[4] = ctl_cfg; rd_next[5] = ctl_ldr;  rd_next[6] = ctl_fail;
      end
      OFS_W'(OFS_ADDR): rd_next = addr_q;
      OFS_W'(OFS_DATA): rd_next = data_q;
      OFS_W'(OFS_CMD):  rd_next[CMD_W-1:0] = cmd_q;
      OFS_W'(OFS_TRG):  rd_next[0] = go;
      OFS_W'(OFS_DBAS): rd_next = DATA_BASE;
      OFS_W'(OFS_TIM):  rd_next[TIM_W-1:0] = tim_q;
      OFS_W'(OFS_KEY):  rd_next[0] = unlocked;
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign fl_cmd   = cmd_q[1:0];
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ctl_fail && !(wr_ctl && unlocked && reg_wdata[6])) |=> ctl_fail);
  assert_locked_ctl_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !unlocked) |=> $stable(ctl_en) && $stable(ctl_boot));
  assert_busy_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    go |=> $stable(addr_q));
  assert_no_start_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(go) |-> $past(ctl_en));
endmodule

// File: tb/flash_isp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_isp_ctrl_bench;
  localparam int LAT = 3;
  localparam logic [31:0] APP = 32'h0000_8000, LB = 32'h0010_0000, LS = 32'h0000_1000;
  localparam logic [31:0] CB = 32'h0030_0000, CS = 32'h0000_0008, DB = 32'h0000_7000;
  localparam logic [31:0] RMASK = 32'hA5A5_0000;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, fl_done = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, fl_addr, fl_wdata, fl_rdata;
  logic fl_req;
  logic [1:0] fl_cmd;
  int tests = 0, fails = 0, req_cnt = 0, fcnt = 0;
  logic [1:0]  last_cmd;
  logic [31:0] last_wd;

  always #2.5 clk = ~clk;
  assign fl_rdata = fl_addr ^ RMASK;

  flash_isp_ctrl u_flash_isp_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_rdata(fl_rdata));

  // flash macro model: done after LAT cycles of request
  initial forever begin
    @(negedge clk);
    if (fl_req) begin
      if (fcnt == LAT - 1) begin
        fl_done = 1'b1; fcnt = 0; req_cnt++; last_cmd = fl_cmd; last_wd = fl_wdata;
      end else begin
        fl_done = 1'b0; fcnt++;
      end
    end else begin
      fl_done = 1'b0; fcnt = 0;
    end
  end

  // behavioural reference model
  bit m_en, m_boot, m_app, m_cfg, m_ldr, m_fail, m_go, m_req;
  logic [31:0] m_addr, m_data, exp_rd;
  logic [5:0] m_cmd;
  logic [4:0] m_tim;
  int m_key, m_ph;

  function automatic bit refused(input logic [31:0] a, input logic [3:0] c,
                                 input bit boot, app, ldr, cfg);
    bit ia, il, ic;
    ia = a < APP; il = (a >= LB) && (a < LB + LS); ic = (a >= CB) && (a < CB + CS);
    if (c > 4'd2) return 1'b1;
    if (a % 4 != 0) return 1'b1;
    if (!(ia || il || ic)) return 1'b1;
    if (c != 4'd0) begin
      if (ia && !boot && !app) return 1'b1;
      if (il && boot) return 1'b1;
      if (il && !ldr) return 1'b1;
      if (ic && !cfg) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit unl, n_fail, n_go, n_req;
    int n_ph, n_key;
    logic [31:0] n_data;
    if (rst) begin
      {m_en, m_app, m_cfg, m_ldr, m_fail, m_go, m_req} = '0; m_boot = 1'b0;
      m_addr = '0; m_data = '0; m_cmd = '0; m_tim = '0; m_key = 0; m_ph = 0; exp_rd = '0;
    end else begin
      unl = (m_key == 3);
      case (reg_addr)
        5'h00: exp_rd = {25'd0, m_fail, m_ldr, m_cfg, m_app, 1'b0, m_boot, m_en};
        5'h04: exp_rd = m_addr;
        5'h08: exp_rd = m_data;
        5'h0C: exp_rd = {26'd0, m_cmd};
        5'h10: exp_rd = {31'd0, m_go};
        5'h14: exp_rd = DB;
        5'h18: exp_rd = {27'd0, m_tim};
        5'h1C: exp_rd = {31'd0, unl};
        default: exp_rd = '0;
      endcase
      n_fail = m_fail; n_go = m_go; n_req = m_req; n_ph = m_ph; n_key = m_key; n_data = m_data;
      if (m_ph == 1) begin
        if (refused(m_addr, m_cmd[3:0], m_boot, m_app, m_ldr, m_cfg)) begin
          n_fail = 1'b1; n_go = 1'b0; n_ph = 0;
        end else begin
          n_req = 1'b1; n_ph = 2;
        end
      end else if (m_ph == 2 && fl_done) begin
        n_req = 1'b0; n_go = 1'b0; n_ph = 0;
        if (m_cmd[3:0] == 4'd0) n_data = fl_rdata;
      end
      if (reg_wr) begin
        case (reg_addr)
          5'h00: if (unl) begin
            m_en = reg_wdata[0]; m_boot = reg_wdata[1]; m_app = reg_wdata[3];
            m_cfg = reg_wdata[4]; m_ldr = reg_wdata[5];
            if (reg_wdata[6] && !(m_ph == 1 && n_fail && !m_fail)) n_fail = 1'b0;
          end
          5'h04: if (!m_go) m_addr = reg_wdata;
          5'h08: if (!m_go) n_data = reg_wdata;
          5'h0C: if (!m_go) m_cmd = reg_wdata[5:0];
          5'h10: if (unl && reg_wdata[0] && m_en && !m_go) begin n_go = 1'b1; n_ph = 1; end
          5'h18: if (unl) m_tim = reg_wdata[4:0];
          5'h1C: begin
            if (m_key == 3) n_key = 0;
            else if (reg_wdata[7:0] == (m_key == 0 ? 8'h59 : m_key == 1 ? 8'h16 : 8'h88))
              n_key = m_key + 1;
            else n_key = 0;
          end
          default: ;
        endcase
      end
      m_fail = n_fail; m_go = n_go; m_req = n_req; m_ph = n_ph; m_key = n_key; m_data = n_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R2 per-cycle read data vs model", reg_rdata, exp_rd);
    chk("R8 per-cycle request vs model", {31'd0, fl_req}, {31'd0, m_req});
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_wr = 1'b0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask
  task automatic unlock();
    wr(5'h1C, 32'h59); wr(5'h1C, 32'h16); wr(5'h1C, 32'h88);
  endtask
  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin rd(5'h10, v); if (v == 0) break; end
  endtask
  task automatic op(input logic [31:0] a, input logic [31:0] c);
    wr(5'h04, a); wr(5'h0C, c); wr(5'h10, 32'h1); wait_idle();
  endtask
  task automatic clear_fail(input logic [31:0] ctl);
    wr(5'h00, ctl | 32'h40);
  endtask

  initial begin
    logic [31:0] v;
    int rq;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(5'h00, v); chk("R1 control after reset", v, 32'h0);
    rd(5'h10, v); chk("R1 trigger after reset", v, 32'h0);
    rd(5'h1C, v); chk("R1 gate locked after reset", v, 32'h0);
    chk("R1 no request after reset", {31'd0, fl_req}, 32'h0);
    // R2 constant base and unmapped offset
    rd(5'h14, v); chk("R2 data base constant", v, DB);
    rd(5'h01, v); chk("R2 unmapped offset reads 0", v, 32'h0);
    // R4 locked writes ignored
    wr(5'h00, 32'h3B); rd(5'h00, v); chk("R4 locked control write", v, 32'h0);
    wr(5'h18, 32'h1F); rd(5'h18, v); chk("R4 locked timing write", v, 32'h0);
    // R3 broken sequence then full unlock
    wr(5'h1C, 32'h59); wr(5'h1C, 32'h16); wr(5'h1C, 32'h00); wr(5'h1C, 32'h88);
    rd(5'h1C, v); chk("R3 broken order stays locked", v, 32'h0);
    unlock(); rd(5'h1C, v); chk("R3 unlocked after key", v, 32'h1);
    wr(5'h1C, 32'h59); rd(5'h1C, v); chk("R3 relock on write", v, 32'h0);
    unlock();
    wr(5'h18, 32'h15); rd(5'h18, v); chk("R4 timing write when open", v, 32'h15);
    // R5 plain registers
    wr(5'h04, 32'h100); wr(5'h08, 32'hCAFE_0001); wr(5'h0C, 32'h31);
    rd(5'h04, v); chk("R5 address write", v, 32'h100);
    rd(5'h08, v); chk("R5 data write", v, 32'hCAFE_0001);
    rd(5'h0C, v); chk("R5 command write", v, 32'h31);
    // R6 disabled trigger ignored
    wr(5'h00, 32'h0); rq = req_cnt;
    wr(5'h0C, 32'h0); wr(5'h10, 32'h1);
    rd(5'h10, v); chk("R6 trigger ignored when disabled", v, 32'h0);
    chk("R6 no request when disabled", req_cnt, rq);
    // R8 read operation
    wr(5'h00, 32'h01); rq = req_cnt;
    op(32'h100, 32'h0);
    rd(5'h08, v); chk("R8 read data loaded", v, 32'h100 ^ RMASK);
    chk("R8 one request", req_cnt, rq + 1);
    rd(5'h00, v); chk("R8 no fail on legal read", v, 32'h01);
    // R5 busy writes dropped, R8 program
    wr(5'h00, 32'h09); wr(5'h08, 32'h1234); wr(5'h04, 32'h104); wr(5'h0C, 32'h1);
    wr(5'h10, 32'h1); wr(5'h08, 32'hDEAD); wr(5'h04, 32'h200); wait_idle();
    rd(5'h08, v); chk("R5 data write dropped while busy", v, 32'h1234);
    rd(5'h04, v); chk("R5 address write dropped while busy", v, 32'h104);
    chk("R8 program data to flash", last_wd, 32'h1234);
    chk("R8 program command to flash", {30'd0, last_cmd}, 32'h1);
    // R9 permissions
    wr(5'h00, 32'h01); rq = req_cnt; op(32'h104, 32'h1);
    rd(5'h00, v); chk("R9 app self-write refused", v, 32'h41);
    chk("R9 refused raises no request", req_cnt, rq);
    // R11 sticky flag
    wr(5'h00, 32'h01); rd(5'h00, v); chk("R11 writing 0 keeps flag", v, 32'h41);
    clear_fail(32'h01); rd(5'h00, v); chk("R11 write 1 clears flag", v, 32'h01);
    wr(5'h00, 32'h3B); op(LB, 32'h1);
    rd(5'h00, v); chk("R9 loader writes itself refused", v, 32'h7B);
    clear_fail(32'h19); op(LB, 32'h1);
    rd(5'h00, v); chk("R9 loader needs its enable", v, 32'h59);
    clear_fail(32'h21); rq = req_cnt; op(LB, 32'h2);
    rd(5'h00, v); chk("R9 loader erase allowed", v, 32'h21);
    chk("R9 erase reached flash", req_cnt, rq + 1);
    wr(5'h00, 32'h01); op(CB, 32'h1);
    rd(5'h00, v); chk("R9 config needs its enable", v, 32'h41);
    clear_fail(32'h11); op(CB + 4, 32'h1);
    rd(5'h00, v); chk("R9 config program allowed", v, 32'h11);
    wr(5'h00, 32'h01); op(CB, 32'h0);
    rd(5'h00, v); chk("R9 config read allowed", v, 32'h01);
    // R10 address legality
    op(32'h102, 32'h0); rd(5'h00, v); chk("R10 misaligned refused", v, 32'h41);
    clear_fail(32'h01); op(APP, 32'h0); rd(5'h00, v); chk("R10 past app end refused", v, 32'h41);
    clear_fail(32'h01); op(APP - 4, 32'h0); rd(5'h00, v); chk("R10 last app word ok", v, 32'h01);
    op(LB + LS, 32'h0); rd(5'h00, v); chk("R10 past loader end refused", v, 32'h41);
    clear_fail(32'h01);
    // R7 unknown codes
    rq = req_cnt; op(32'h0, 32'h3); rd(5'h00, v); chk("R7 code 3 refused", v, 32'h41);
    clear_fail(32'h01); op(32'h0, 32'hF); rd(5'h00, v); chk("R7 code F refused", v, 32'h41);
    chk("R7 no request for unknown code", req_cnt, rq);
    // R4 locked again: control, trigger, fail clear ignored
    wr(5'h1C, 32'h0);
    wr(5'h00, 32'h40); rd(5'h00, v); chk("R4 locked clear ignored", v, 32'h41);
    wr(5'h0C, 32'h0); rq = req_cnt; wr(5'h10, 32'h1);
    rd(5'h10, v); chk("R4 locked trigger ignored", v, 32'h0);
    chk("R4 no request when locked", req_cnt, rq);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule